// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight peripheral interrupt lines and presents a single interrupt request to a processor. Each line's rising edge is latched as a pending request. A software-written mask removes individual lines from consideration. The surviving requests are ranked by a fixed priority: line 0 is the most urgent and line 7 the least.

When the processor answers the request with an acknowledge, the controller places an 8-bit vector naming the winning line on the data bus for that one cycle. The processor uses the vector to branch directly to the matching handler, with no polling. The controller then marks that level as being serviced. While a level is in service, only strictly more urgent lines may raise a new request, so handlers nest by priority. An end-of-service strobe retires the most urgent level currently in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, no request is pending and no level is in service. All eight lines are masked (mask bits all 1) and the vector base is zero. `intReq` and `vecOe` are low and `vecData` is zero.
- R2: A low-to-high change on `irqLines[i]`, sampled at a clock edge, sets pending bit i. A line that simply stays high does not set it again once it has been cleared.
- R3: Writing `maskData` with `maskWe` high loads the mask, where bit i = 1 masks line i. A masked line never causes `intReq`, but its pending bit is kept. Unmasking it later raises `intReq` in the following cycle.
- R4: Among pending, unmasked lines, the lowest index wins.
- R5: `intReq` is high in the cycle after the edge that latched an eligible request, provided the winner may be taken (see R8).
- R6: In a cycle where `intAck` and `intReq` are both high, `vecOe` is 1 and `vecData` equals {base, winner index}, with the 3-bit index in bits 2:0 and the 5-bit base in bits 7:3. In every other cycle, `vecOe` is 0 and `vecData` is 0. An `intAck` while `intReq` is low changes no state.
- R7: An accepted acknowledge clears the winner's pending bit and sets its in-service bit at that clock edge.
- R8: `intReq` is raised only if the winner's index is lower than the lowest in-service index, or nothing is in service. Requests of equal or lower priority wait.
- R9: An `eoiStrobe` cycle clears only the lowest-indexed in-service bit. When nothing is in service, it has no effect.
- R10: Writing `baseData` with `baseWe` high loads the 5-bit vector base used by later acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 8 | Peripheral interrupt lines, edge-sensitive |
| maskWe | input | 1 | Load strobe for the mask |
| maskData | input | 8 | New mask, 1 = line blocked |
| baseWe | input | 1 | Load strobe for the vector base |
| baseData | input | 5 | New vector base |
| intAck | input | 1 | Processor acknowledge |
| eoiStrobe | input | 1 | End of service for the most urgent active level |
| intReq | output | 1 | Interrupt request to the processor |
| vecData | output | 8 | Vector driven during an accepted acknowledge |
| vecOe | output | 1 | Data bus enable for the vector |

## Verification
The assertions watch, on every cycle, the rules that involve only the current cycle or one step back:
- the vector appears only together with an acknowledge and is zero otherwise;
- the chosen winner is never a masked line;
- an accepted acknowledge never takes a level that is equal to or lower than the in-service level;
- an accepted acknowledge leaves the winner in service;
- each end-of-service retires exactly one level.

Only the bench scenarios can show the multi-step behaviour. This covers which index wins a simultaneous request, the vector value built from a reprogrammed base, nested preemption followed by release in the right order, a held line not re-triggering, and a spurious acknowledge leaving the state unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ackTake;
    logic eoiTake;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  reqVec,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqVec[i]) idx = IW'(i);
    end
    valid = |reqVec;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int VW = 8,
  localparam int BW = VW - IW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  irqLines,
  input  logic          maskWe,
  input  logic [N-1:0]  maskData,
  input  logic          baseWe,
  input  logic [BW-1:0] baseData,
  input  ctrlStrobe_t   strobe,
  output logic          winValid,
  output logic [IW-1:0] winIdx,
  output logic          isrValid,
  output logic [IW-1:0] isrIdx,
  output logic [VW-1:0] vecData,
  output logic          vecOe
);
  logic [N-1:0]  irqPrev, pendReg, maskReg, isrReg;
  logic [BW-1:0] baseReg;
  logic [N-1:0]  riseVec, eligVec, ackClr, eoiClr;

  assign riseVec = irqLines & ~irqPrev;
  assign eligVec = pendReg & ~maskReg;

  irq_prio_enc #(.N(N), .IW(IW)) u_winEnc (
    .reqVec(eligVec), .valid(winValid), .idx(winIdx)
  );
  irq_prio_enc #(.N(N), .IW(IW)) u_isrEnc (
    .reqVec(isrReg), .valid(isrValid), .idx(isrIdx)
  );

  assign ackClr = strobe.ackTake ? (N'(1) << winIdx) : '0;
  assign eoiClr = (strobe.eoiTake && isrValid) ? (N'(1) << isrIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev <= '0;
      pendReg <= '0;
      maskReg <= '1;
      isrReg  <= '0;
      baseReg <= '0;
    end else begin
      irqPrev <= irqLines;
      pendReg <= (pendReg & ~ackClr) | riseVec;
      isrReg  <= (isrReg & ~eoiClr) | ackClr;
      if (maskWe) maskReg <= maskData;
      if (baseWe) baseReg <= baseData;
    end
  end

  assign vecOe   = strobe.ackTake;
  assign vecData = strobe.ackTake ? {baseReg, winIdx} : '0;

  // R3
  masked_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> !maskReg[winIdx]);
  // R8
  nest_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackTake && isrValid) |-> (winIdx < isrIdx));
  // R7
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> isrReg[$past(winIdx)]);
  // R9
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiTake && isrValid && !strobe.ackTake) |=>
      ($countones(isrReg) == $countones($past(isrReg)) - 1));
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          winValid,
  input  logic [IW-1:0] winIdx,
  input  logic          isrValid,
  input  logic [IW-1:0] isrIdx,
  input  logic          intAck,
  input  logic          eoiStrobe,
  output logic          intReq,
  output ctrlStrobe_t   strobe
);
  // only strictly more urgent levels may nest
  assign intReq         = winValid && (!isrValid || (winIdx < isrIdx));
  assign strobe.ackTake = intAck && intReq;
  assign strobe.eoiTake = eoiStrobe;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int VW = 8,
  localparam int IW = $clog2(N),
  localparam int BW = VW - IW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  irqLines,
  input  logic          maskWe,
  input  logic [N-1:0]  maskData,
  input  logic          baseWe,
  input  logic [BW-1:0] baseData,
  input  logic          intAck,
  input  logic          eoiStrobe,
  output logic          intReq,
  output logic [VW-1:0] vecData,
  output logic          vecOe
);
  ctrlStrobe_t   strobe;
  logic          winValid, isrValid;
  logic [IW-1:0] winIdx, isrIdx;

  irq_datapath #(.N(N), .IW(IW), .VW(VW)) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines),
    .maskWe(maskWe), .maskData(maskData),
    .baseWe(baseWe), .baseData(baseData),
    .strobe(strobe),
    .winValid(winValid), .winIdx(winIdx),
    .isrValid(isrValid), .isrIdx(isrIdx),
    .vecData(vecData), .vecOe(vecOe)
  );

  irq_control #(.N(N), .IW(IW)) u_ctl (
    .winValid(winValid), .winIdx(winIdx),
    .isrValid(isrValid), .isrIdx(isrIdx),
    .intAck(intAck), .eoiStrobe(eoiStrobe),
    .intReq(intReq), .strobe(strobe)
  );

  // R6
  vec_only_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (intAck && intReq));
  // R6
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecOe |-> (vecData == '0));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqLines;
  logic       maskWe;
  logic [7:0] maskData;
  logic       baseWe;
  logic [4:0] baseData;
  logic       intAck;
  logic       eoiStrobe;
  logic       intReq;
  logic [7:0] vecData;
  logic       vecOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [4:0] curBase = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines),
    .maskWe(maskWe), .maskData(maskData),
    .baseWe(baseWe), .baseData(baseData),
    .intAck(intAck), .eoiStrobe(eoiStrobe),
    .intReq(intReq), .vecData(vecData), .vecOe(vecOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change at the falling edge; checks 1 time unit later
  task automatic nextCyc();
    @(negedge clk);
    #1;
  endtask

  task automatic doAck(input int expIdx, input string req);
    @(negedge clk);
    intAck = 1'b1;
    #1;
    chk(vecOe == 1'b1, req, vecOe, 1);
    chk(vecData == {curBase, 3'(expIdx)}, req, vecData, {curBase, 3'(expIdx)});
    @(negedge clk);
    intAck = 1'b0;
    #1;
  endtask

  task automatic doEoi();
    @(negedge clk);
    eoiStrobe = 1'b1;
    @(negedge clk);
    eoiStrobe = 1'b0;
    #1;
  endtask

  task automatic setLine(input int i, input logic v);
    @(negedge clk);
    irqLines[i] = v;
    #1;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    irqLines = '0; maskWe = 0; maskData = '0; baseWe = 0; baseData = '0;
    intAck = 0; eoiStrobe = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(intReq == 0, "R1", intReq, 0);
    chk(vecOe == 0, "R1", vecOe, 0);
    chk(vecData == 0, "R1", vecData, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testMaskBase();
    setLine(3, 1'b1);
    nextCyc();
    // R1 all masked after reset, R3 masked line gives no request
    chk(intReq == 0, "R3", intReq, 0);
    irqLines[3] = 1'b0;
    maskWe = 1; maskData = 8'h00; baseWe = 1; baseData = 5'h15;
    nextCyc();
    maskWe = 0; baseWe = 0;
    curBase = 5'h15;
    // R3 pending kept while masked
    chk(intReq == 1, "R3", intReq, 1);
    // R6 no ack means no vector
    chk(vecOe == 0 && vecData == 0, "R6", vecData, 0);
    doAck(3, "R10");
    // R7 pending cleared and level in service
    chk(intReq == 0, "R7", intReq, 0);
    doEoi();
  endtask

  task automatic testPriority();
    @(negedge clk);
    irqLines[5] = 1'b1; irqLines[2] = 1'b1;
    nextCyc();
    // R5
    chk(intReq == 1, "R5", intReq, 1);
    doAck(2, "R4");
    // R8 lower priority waits behind level 2
    chk(intReq == 0, "R8", intReq, 0);
    doEoi();
    chk(intReq == 1, "R9", intReq, 1);
    doAck(5, "R4");
    doEoi();
    @(negedge clk);
    irqLines = '0;
  endtask

  task automatic testNesting();
    setLine(6, 1'b1);
    nextCyc();
    doAck(6, "R8");
    setLine(4, 1'b1);
    nextCyc();
    // R8 more urgent line preempts
    chk(intReq == 1, "R8", intReq, 1);
    doAck(4, "R8");
    setLine(4, 1'b0);
    setLine(4, 1'b1);
    nextCyc();
    // R8 equal priority waits
    chk(intReq == 0, "R8", intReq, 0);
    doEoi();
    // R9 only level 4 retired, so 4 now beats 6
    chk(intReq == 1, "R9", intReq, 1);
    doAck(4, "R9");
    doEoi();
    doEoi();
    doEoi();
    // R9 eoi with nothing in service is harmless
    chk(intReq == 0, "R9", intReq, 0);
    @(negedge clk);
    irqLines = '0;
  endtask

  task automatic testLevelHeld();
    setLine(1, 1'b1);
    nextCyc();
    doAck(1, "R2");
    doEoi();
    repeat (4) nextCyc();
    // R2 held line does not re-trigger
    chk(intReq == 0, "R2", intReq, 0);
    @(negedge clk);
    irqLines[1] = 1'b0;
  endtask

  task automatic testSpuriousAck();
    @(negedge clk);
    intAck = 1'b1;
    #1;
    // R6 ack without request drives nothing
    chk(vecOe == 0, "R6", vecOe, 0);
    chk(vecData == 0, "R6", vecData, 0);
    @(negedge clk);
    intAck = 1'b0;
    baseWe = 1; baseData = 5'h02;
    @(negedge clk);
    baseWe = 0;
    curBase = 5'h02;
    setLine(7, 1'b1);
    nextCyc();
    chk(intReq == 1, "R5", intReq, 1);
    doAck(7, "R10");
    doEoi();
    chk(intReq == 0, "R6", intReq, 0);
  endtask

  initial begin
    testReset();
    testMaskBase();
    testPriority();
    testNesting();
    testLevelHeld();
    testSpuriousAck();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule